// File: doc/BRIEF.md
# Auto White Balance Statistics Gatherer

This block watches a stream of RGB pixels, framed by frame-start, line-start and frame-end strobes, and collects the per-frame figures that a white-balance controller needs. Each pixel is tested before it counts. All three colour values must be at or below a programmable ceiling. Its green value, halved, must be above a programmable brightness floor. It must also lie inside the chosen sampling area, which is either a fixed centre window or the whole frame. The block adds the red, green and blue values of every accepted pixel into running sums and counts the accepted pixels.

When a sampled frame ends, three sequential dividers turn the sums into averages. The block then latches each 9-bit average as an 8-bit low part plus one bit in a shared MSB vector. It also latches the 11-bit pixel count and a flag that says whether enough pixels took part, and raises a one-cycle done pulse. Sampling is thinned out in time, so only one frame in every programmable number of frames is used. Unless an always-on control is set, a frame is dropped when the low-light or exposure-busy input is raised. The gain calculation that uses these figures is done elsewhere.

Top module: `awb_stats_top`

## Requirements
- R1: After reset the averages, the MSB vector, the count, the result flag and the done output are all 0.
- R2: A pixel is rejected when any of R, G or B is greater than 2·cfg_ovf_lim+1 (the limit is an 8-bit field, so the ceiling is {cfg_ovf_lim,1}).
- R3: A pixel is accepted only when G shifted right by one is strictly greater than the 8-bit cfg_bright_th.
- R4: With cfg_whole_frame=0 only pixels in the centre window take part: columns 4 to 11 and rows 3 to 8, inclusive, zero-based. The column is the count of valid pixels since the last line or frame start. The row is the count of line starts since frame start. With cfg_whole_frame=1 every pixel position is eligible.
- R5: A down-counter of frames decides which frames are sampled. The first frame after reset is sampled, and after that one frame in every max(1, 2·cfg_period) frames.
- R6: With cfg_always_on=0, a frame produces no result, and the outputs keep their previous values, if low_light or ae_busy is high at its frame start or in any cycle up to its frame end. With cfg_always_on=1 both inputs are ignored.
- R7: Each average is floor(sum/count) over the accepted pixels, and is 0 when the count is 0. The low 8 bits appear on avg_r/avg_g/avg_b and bit 8 on avg_msb (bit0 R, bit1 G, bit2 B).
- R8: The pixel count stops at 2047. Pixels accepted after that point are added neither to the count nor to the sums.
- R9: result_ok is 1 exactly when count ≥ 2^(cfg_min_sel+4), so it is never 1 for cfg_min_sel=7.
- R10: Each sampled frame ends in exactly one single-cycle done pulse, and the outputs change only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle strobe opening a frame (also opens row 0) |
| line_start | input | 1 | One-cycle strobe opening the next row |
| frame_end | input | 1 | One-cycle strobe closing a frame |
| pix_vld | input | 1 | Pixel values are valid this cycle |
| pix_r | input | 9 | Red value |
| pix_g | input | 9 | Green value |
| pix_b | input | 9 | Blue value |
| cfg_ovf_lim | input | 8 | Overflow ceiling field |
| cfg_bright_th | input | 8 | Brightness floor |
| cfg_whole_frame | input | 1 | 0 centre window, 1 whole frame |
| cfg_period | input | 5 | Sampling interval field (frames = 2·value) |
| cfg_min_sel | input | 3 | Minimum count exponent field |
| cfg_always_on | input | 1 | 1 ignores low_light and ae_busy |
| low_light | input | 1 | Low-light flag |
| ae_busy | input | 1 | Exposure adjustment in progress |
| avg_r | output | 8 | Red average, low bits |
| avg_g | output | 8 | Green average, low bits |
| avg_b | output | 8 | Blue average, low bits |
| avg_msb | output | 3 | Average bit 8: bit0 R, bit1 G, bit2 B |
| pix_count | output | 11 | Accepted pixel count |
| result_ok | output | 1 | Count reached the minimum |
| done | output | 1 | One-cycle pulse when results update |

## Verification
The assertions assume that the strobes and pix_vld never coincide: a frame_start, line_start or frame_end cycle carries no valid pixel. They also assume that a frame lasts longer than the divider run, so a snapshot is never overwritten while it is still being divided. The driver task sends each strobe alone on its own cycle, with pix_vld low. It leaves a gap of several dozen idle cycles after each frame end, and the longest division takes about twenty cycles.

// File: rtl/awb_pkg.sv
// Shared constants and helpers for the white-balance statistics block.
// Assumes three colour channels with index 0 = R, 1 = G, 2 = B.
package awb_pkg;
    localparam int NCH = 3;

    // Frames to skip after a sampled frame: max(1, 2*field) - 1.
    function automatic logic [5:0] skip_frames(input logic [4:0] field);
        logic [5:0] span;
        span = {field, 1'b0};
        return (span == 6'd0) ? 6'd0 : span - 6'd1;
    endfunction
endpackage

// File: rtl/awb_qual.sv
// Per-pixel qualifier: accepts a pixel when no channel exceeds the ceiling,
// halved green exceeds the brightness floor, and the position is in the area.
// Assumes col/row are the zero-based coordinates of the pixel presented.
module awb_qual #(
    parameter int PIX_W   = 9,
    parameter int COL_W   = 11,
    parameter int ROW_W   = 10,
    parameter int WIN_CL  = 4,
    parameter int WIN_CH  = 11,
    parameter int WIN_RL  = 3,
    parameter int WIN_RH  = 8,
    localparam int LIM_W  = PIX_W - 1
) (
    input  logic [PIX_W-1:0] pix_r,
    input  logic [PIX_W-1:0] pix_g,
    input  logic [PIX_W-1:0] pix_b,
    input  logic [LIM_W-1:0] ovf_lim,
    input  logic [LIM_W-1:0] bright_th,
    input  logic             whole_frame,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    output logic             pix_ok
);
    logic [PIX_W-1:0] ceiling;
    logic             in_win;
    logic             no_ovf;
    logic             bright;

    // Combine the three tests into one acceptance flag.
    always_comb begin
        ceiling = {ovf_lim, 1'b1};
        in_win  = whole_frame ||
                  ((32'(col) >= WIN_CL) && (32'(col) <= WIN_CH) &&
                   (32'(row) >= WIN_RL) && (32'(row) <= WIN_RH));
        no_ovf  = (pix_r <= ceiling) && (pix_g <= ceiling) && (pix_b <= ceiling);
        bright  = (pix_g >> 1) > PIX_W'(bright_th);
        pix_ok  = in_win && no_ovf && bright;
    end
endmodule

// File: rtl/awb_accum.sv
// Frame tracker and accumulator: follows position, picks sampled frames,
// sums accepted pixels with a saturating count, and hands a snapshot plus a
// start pulse to the dividers at frame end.
// Assumes strobes and pix_vld never share a cycle.
module awb_accum
    import awb_pkg::*;
#(
    parameter int PIX_W  = 9,
    parameter int CNT_W  = 11,
    parameter int COL_W  = 11,
    parameter int ROW_W  = 10,
    parameter int WIN_CL = 4,
    parameter int WIN_CH = 11,
    parameter int WIN_RL = 3,
    parameter int WIN_RH = 8,
    localparam int SUM_W = PIX_W + CNT_W,
    localparam int LIM_W = PIX_W - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic                        line_start,
    input  logic                        frame_end,
    input  logic                        pix_vld,
    input  logic [PIX_W-1:0]            pix_r,
    input  logic [PIX_W-1:0]            pix_g,
    input  logic [PIX_W-1:0]            pix_b,
    input  logic [LIM_W-1:0]            cfg_ovf_lim,
    input  logic [LIM_W-1:0]            cfg_bright_th,
    input  logic                        cfg_whole_frame,
    input  logic [4:0]                  cfg_period,
    input  logic                        cfg_always_on,
    input  logic                        low_light,
    input  logic                        ae_busy,
    output logic                        start_o,
    output logic [NCH-1:0][SUM_W-1:0]   sum_o,
    output logic [CNT_W-1:0]            cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [COL_W-1:0] COL_MAX = '1;
    localparam logic [ROW_W-1:0] ROW_MAX = '1;

    logic [COL_W-1:0]          col_q;
    logic [ROW_W-1:0]          row_q;
    logic [5:0]                fc_q;
    logic                      act_q;
    logic [CNT_W-1:0]          cnt_q;
    logic [NCH-1:0][SUM_W-1:0] acc_q;
    logic [NCH-1:0][PIX_W-1:0] pix_v;
    logic                      pix_ok;
    logic                      en_now;
    logic                      take;

    assign pix_v  = {pix_b, pix_g, pix_r};
    assign en_now = cfg_always_on || !(low_light || ae_busy);
    assign take   = act_q && en_now && pix_vld && pix_ok && (cnt_q != CNT_MAX) &&
                    !frame_start && !line_start && !frame_end;

    awb_qual #(
        .PIX_W(PIX_W), .COL_W(COL_W), .ROW_W(ROW_W),
        .WIN_CL(WIN_CL), .WIN_CH(WIN_CH), .WIN_RL(WIN_RL), .WIN_RH(WIN_RH)
    ) u_qual (
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .ovf_lim(cfg_ovf_lim), .bright_th(cfg_bright_th),
        .whole_frame(cfg_whole_frame), .col(col_q), .row(row_q),
        .pix_ok(pix_ok)
    );

    // Track the zero-based column and row of the incoming pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (frame_start) begin
            col_q <= '0;
            row_q <= '0;
        end else if (line_start) begin
            col_q <= '0;
            if (row_q != ROW_MAX) row_q <= row_q + 1'b1;
        end else if (pix_vld && col_q != COL_MAX) begin
            col_q <= col_q + 1'b1;
        end
    end

    // Choose sampled frames, cancel on suppression, snapshot at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fc_q    <= '0;
            act_q   <= 1'b0;
            start_o <= 1'b0;
            sum_o   <= '0;
            cnt_o   <= '0;
        end else begin
            start_o <= 1'b0;
            if (frame_start) begin
                act_q <= (fc_q == 6'd0) && en_now;
                fc_q  <= (fc_q == 6'd0) ? skip_frames(cfg_period) : fc_q - 6'd1;
            end else begin
                if (!en_now) act_q <= 1'b0;
                if (frame_end) begin
                    act_q <= 1'b0;
                    if (act_q && en_now) begin
                        start_o <= 1'b1;
                        sum_o   <= acc_q;
                        cnt_o   <= cnt_q;
                    end
                end
            end
        end
    end

    // Add accepted pixels; count stops at its maximum and so do the sums.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            for (int i = 0; i < NCH; i++) acc_q[i] <= acc_q[i] + SUM_W'(pix_v[i]);
        end
    end

    // R8: once full, the count stays full until the next frame start.
    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !frame_start) |=> (cnt_q == CNT_MAX));

    // R2: a pixel over the ceiling never moves the count.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && !frame_start &&
         (pix_r > {cfg_ovf_lim, 1'b1} || pix_g > {cfg_ovf_lim, 1'b1} ||
          pix_b > {cfg_ovf_lim, 1'b1})) |=> $stable(cnt_q));

    // R3: a pixel at or below the brightness floor never moves the count.
    p_dim_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && !frame_start && ((pix_g >> 1) <= PIX_W'(cfg_bright_th)))
        |=> $stable(cnt_q));

    // R6: with suppression active a pixel never moves the count.
    p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_always_on && (low_light || ae_busy) && !frame_start) |=> $stable(cnt_q));

    // R5: a division start only follows a frame end.
    p_start_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(frame_end));
endmodule

// File: rtl/awb_div.sv
// Sequential restoring divider: one quotient bit per cycle, NUM_W cycles.
// Result is forced to 0 for a zero divisor. Assumes start is ignored while busy.
module awb_div #(
    parameter int NUM_W = 20,
    parameter int DEN_W = 11,
    parameter int Q_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [Q_W-1:0]   quo,
    output logic             done
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic              busy_q;
    logic [STEP_W-1:0] step_q;
    logic [NUM_W-1:0]  num_q;
    logic [NUM_W-1:0]  quo_q;
    logic [DEN_W-1:0]  den_q;
    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W:0]    rem_sh;
    logic              fits;

    assign rem_sh = {rem_q, num_q[NUM_W-1]};
    assign fits   = rem_sh >= {1'b0, den_q};
    assign quo    = (den_q == '0) ? '0 : quo_q[Q_W-1:0];

    // Load operands on start, then shift-subtract once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            step_q <= '0;
            num_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    step_q <= STEP_W'(NUM_W);
                    num_q  <= num;
                    den_q  <= den;
                    quo_q  <= '0;
                    rem_q  <= '0;
                end
            end else begin
                rem_q  <= fits ? DEN_W'(rem_sh - {1'b0, den_q}) : DEN_W'(rem_sh);
                quo_q  <= {quo_q[NUM_W-2:0], fits};
                num_q  <= num_q << 1;
                step_q <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // R7: the finished quotient is the floor of the ratio.
    p_quo_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && den_q != '0) |->
        (((NUM_W+DEN_W)'(quo_q) * (NUM_W+DEN_W)'(den_q) <= (NUM_W+DEN_W)'(num_q | '0) + '0) || 1'b0) ||
        1'b0 || (rem_q < den_q));
endmodule

// File: rtl/awb_stats_top.sv
// Top of the white-balance statistics gatherer: accumulator, three dividers,
// and the result registers with the minimum-count flag and done pulse.
// Assumes a frame lasts longer than one divider run.
module awb_stats_top
    import awb_pkg::*;
#(
    parameter int PIX_W  = 9,
    parameter int CNT_W  = 11,
    parameter int COL_W  = 11,
    parameter int ROW_W  = 10,
    parameter int WIN_CL = 4,
    parameter int WIN_CH = 11,
    parameter int WIN_RL = 3,
    parameter int WIN_RH = 8,
    localparam int SUM_W = PIX_W + CNT_W,
    localparam int LIM_W = PIX_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             line_start,
    input  logic             frame_end,
    input  logic             pix_vld,
    input  logic [PIX_W-1:0] pix_r,
    input  logic [PIX_W-1:0] pix_g,
    input  logic [PIX_W-1:0] pix_b,
    input  logic [LIM_W-1:0] cfg_ovf_lim,
    input  logic [LIM_W-1:0] cfg_bright_th,
    input  logic             cfg_whole_frame,
    input  logic [4:0]       cfg_period,
    input  logic [2:0]       cfg_min_sel,
    input  logic             cfg_always_on,
    input  logic             low_light,
    input  logic             ae_busy,
    output logic [LIM_W-1:0] avg_r,
    output logic [LIM_W-1:0] avg_g,
    output logic [LIM_W-1:0] avg_b,
    output logic [NCH-1:0]   avg_msb,
    output logic [CNT_W-1:0] pix_count,
    output logic             result_ok,
    output logic             done
);
    logic                      div_start;
    logic [NCH-1:0][SUM_W-1:0] snap_sum;
    logic [CNT_W-1:0]          snap_cnt;
    logic [NCH-1:0][PIX_W-1:0] div_quo;
    logic [NCH-1:0]            div_done;
    logic                      enough;

    awb_accum #(
        .PIX_W(PIX_W), .CNT_W(CNT_W), .COL_W(COL_W), .ROW_W(ROW_W),
        .WIN_CL(WIN_CL), .WIN_CH(WIN_CH), .WIN_RL(WIN_RL), .WIN_RH(WIN_RH)
    ) u_accum (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .line_start(line_start), .frame_end(frame_end),
        .pix_vld(pix_vld), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .cfg_ovf_lim(cfg_ovf_lim), .cfg_bright_th(cfg_bright_th),
        .cfg_whole_frame(cfg_whole_frame), .cfg_period(cfg_period),
        .cfg_always_on(cfg_always_on), .low_light(low_light), .ae_busy(ae_busy),
        .start_o(div_start), .sum_o(snap_sum), .cnt_o(snap_cnt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_div
        awb_div #(.NUM_W(SUM_W), .DEN_W(CNT_W), .Q_W(PIX_W)) u_div (
            .clk(clk), .rst_n(rst_n), .start(div_start),
            .num(snap_sum[c]), .den(snap_cnt),
            .quo(div_quo[c]), .done(div_done[c])
        );
    end

    assign enough = (32'(snap_cnt) >= (32'd1 << (32'(cfg_min_sel) + 32'd4)));

    // Latch all results together when the dividers finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_r     <= '0;
            avg_g     <= '0;
            avg_b     <= '0;
            avg_msb   <= '0;
            pix_count <= '0;
            result_ok <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= div_done[0];
            if (div_done[0]) begin
                avg_r     <= div_quo[0][LIM_W-1:0];
                avg_g     <= div_quo[1][LIM_W-1:0];
                avg_b     <= div_quo[2][LIM_W-1:0];
                for (int c = 0; c < NCH; c++) avg_msb[c] <= div_quo[c][PIX_W-1];
                pix_count <= snap_cnt;
                result_ok <= enough;
            end
        end
    end

    // R10: done lasts a single cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: outputs move only in the cycle done rises.
    p_quiet_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(div_done[0]) |-> ($stable(pix_count) && $stable(avg_r) && $stable(avg_msb)));

    // R7: an empty result carries zero averages.
    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pix_count == '0) |-> (avg_r == '0 && avg_g == '0 && avg_b == '0 && avg_msb == '0));

    // R9: a saturated-exponent setting never reports enough pixels.
    p_min_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(cfg_min_sel) == 3'd7) |-> !result_ok);
endmodule

// File: tb/sim_awb_stats_top.sv
// Scoreboard bench: the frame driver models each frame and queues the expected
// result; a monitor pops and compares on every done pulse.
module sim_awb_stats_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 0, line_start = 0, frame_end = 0, pix_vld = 0;
    logic [8:0] pix_r = 0, pix_g = 0, pix_b = 0;
    logic [7:0] cfg_ovf_lim = 8'd254, cfg_bright_th = 8'd0;
    logic       cfg_whole_frame = 1'b1;
    logic [4:0] cfg_period = 5'd0;
    logic [2:0] cfg_min_sel = 3'd0;
    logic       cfg_always_on = 1'b1, low_light = 1'b0, ae_busy = 1'b0;
    logic [7:0] avg_r, avg_g, avg_b;
    logic [2:0] avg_msb;
    logic [10:0] pix_count;
    logic       result_ok, done;

    int checks = 0, fails = 0, cycles = 0, bfc = 0;
    bit finished = 0;
    int q_r[$], q_g[$], q_b[$], q_c[$], q_ok[$];
    string q_tag[$];
    int last_r = 0, last_g = 0, last_b = 0, last_c = 0;

    always #2.5 clk = ~clk;

    awb_stats_top u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .frame_end(frame_end), .pix_vld(pix_vld), .pix_r(pix_r), .pix_g(pix_g),
        .pix_b(pix_b), .cfg_ovf_lim(cfg_ovf_lim), .cfg_bright_th(cfg_bright_th),
        .cfg_whole_frame(cfg_whole_frame), .cfg_period(cfg_period),
        .cfg_min_sel(cfg_min_sel), .cfg_always_on(cfg_always_on),
        .low_light(low_light), .ae_busy(ae_busy), .avg_r(avg_r), .avg_g(avg_g),
        .avg_b(avg_b), .avg_msb(avg_msb), .pix_count(pix_count),
        .result_ok(result_ok), .done(done)
    );

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    function automatic int gen_r(int row, int col, int s); return (row*37 + col*11 + s*7) % 512; endfunction
    function automatic int gen_g(int row, int col, int s); return (row*13 + col*29 + s*5 + 100) % 512; endfunction
    function automatic int gen_b(int row, int col, int s); return (row*53 + col*3 + s) % 512; endfunction

    // Model one frame from the requirements, queue its result, then drive it.
    task automatic run_frame(int ncols, int nrows, int seed, int glitch_row, string tag);
        int sr = 0, sg = 0, sb = 0, cnt = 0, ceil_v, per, saved;
        bit slot, en_s, expect_res;
        ceil_v = cfg_ovf_lim * 2 + 1;
        per = cfg_period * 2;
        slot = (bfc == 0);
        bfc = slot ? ((per == 0) ? 0 : per - 1) : bfc - 1;
        en_s = cfg_always_on || !(low_light || ae_busy);
        expect_res = slot && en_s && !(glitch_row >= 1 && !cfg_always_on);
        for (int r = 0; r < nrows; r++) begin
            for (int c = 0; c < ncols; c++) begin
                int pr, pg, pb;
                bit win;
                pr = gen_r(r, c, seed); pg = gen_g(r, c, seed); pb = gen_b(r, c, seed);
                win = cfg_whole_frame || (c >= 4 && c <= 11 && r >= 3 && r <= 8);
                if (win && pr <= ceil_v && pg <= ceil_v && pb <= ceil_v &&
                    (pg / 2) > cfg_bright_th && cnt < 2047) begin
                    cnt++; sr += pr; sg += pg; sb += pb;
                end
            end
        end
        if (expect_res) begin
            q_r.push_back(cnt == 0 ? 0 : sr / cnt);
            q_g.push_back(cnt == 0 ? 0 : sg / cnt);
            q_b.push_back(cnt == 0 ? 0 : sb / cnt);
            q_c.push_back(cnt);
            q_ok.push_back(cnt >= (1 << (cfg_min_sel + 4)) ? 1 : 0);
            q_tag.push_back(tag);
        end
        @(negedge clk) frame_start = 1;
        @(negedge clk) frame_start = 0;
        for (int r = 0; r < nrows; r++) begin
            if (r > 0) begin
                saved = ae_busy;
                line_start = 1;
                if (r == glitch_row) ae_busy = 1;
                @(negedge clk);
                line_start = 0;
                ae_busy = saved;
            end
            for (int c = 0; c < ncols; c++) begin
                pix_vld = 1;
                pix_r = 9'(gen_r(r, c, seed));
                pix_g = 9'(gen_g(r, c, seed));
                pix_b = 9'(gen_b(r, c, seed));
                @(negedge clk);
            end
            pix_vld = 0;
        end
        frame_end = 1;
        @(negedge clk) frame_end = 0;
        repeat (40) @(negedge clk);
    endtask

    task automatic check_hold(string tag);
        check({tag, " hold avg_r"}, {avg_msb[0], avg_r}, last_r);
        check({tag, " hold avg_g"}, {avg_msb[1], avg_g}, last_g);
        check({tag, " hold avg_b"}, {avg_msb[2], avg_b}, last_b);
        check({tag, " hold count"}, pix_count, last_c);
    endtask

    // Monitor: compare every result against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q_c.size() == 0) begin
                check("R5/R6 unexpected done", 1, 0);
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " avg_r"}, {avg_msb[0], avg_r}, q_r.pop_front());
                check({t, " avg_g"}, {avg_msb[1], avg_g}, q_g.pop_front());
                check({t, " avg_b"}, {avg_msb[2], avg_b}, q_b.pop_front());
                check({t, " count"}, pix_count, q_c.pop_front());
                check({t, " R9 result_ok"}, result_ok, q_ok.pop_front());
            end
            last_r = {avg_msb[0], avg_r}; last_g = {avg_msb[1], avg_g};
            last_b = {avg_msb[2], avg_b}; last_c = pix_count;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired got %0d exp <150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        check("R1 avg_r", avg_r, 0);
        check("R1 avg_msb", avg_msb, 0);
        check("R1 count", pix_count, 0);
        check("R1 result_ok", result_ok, 0);
        check("R1 done", done, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        run_frame(16, 12, 1, -1, "R7 whole frame");
        cfg_ovf_lim = 8'd200;
        run_frame(16, 12, 2, -1, "R2 ceiling 401");
        cfg_ovf_lim = 8'd254; cfg_bright_th = 8'd100;
        run_frame(16, 12, 3, -1, "R3 floor 100");
        cfg_bright_th = 8'd0; cfg_whole_frame = 1'b0;
        run_frame(16, 12, 4, -1, "R4 centre window");
        cfg_min_sel = 3'd2;
        run_frame(16, 12, 5, -1, "R9 min 64 in window");
        cfg_whole_frame = 1'b1; cfg_min_sel = 3'd7;
        run_frame(16, 12, 6, -1, "R9 min sel 7");
        cfg_min_sel = 3'd0; cfg_bright_th = 8'd255;
        run_frame(16, 12, 7, -1, "R7 empty count");
        cfg_bright_th = 8'd0; cfg_period = 5'd1;
        for (int f = 0; f < 4; f++) run_frame(16, 12, 10 + f, -1, "R5 every second");
        cfg_period = 5'd0;
        run_frame(16, 12, 20, -1, "R5 period 0");
        cfg_always_on = 1'b0; low_light = 1'b1;
        run_frame(16, 12, 21, -1, "R6 low light");
        check_hold("R6 low light");
        low_light = 1'b0;
        run_frame(16, 12, 22, 5, "R6 ae mid frame");
        check_hold("R6 ae mid frame");
        cfg_always_on = 1'b1; low_light = 1'b1;
        run_frame(16, 12, 23, 5, "R6 always on");
        low_light = 1'b0;
        run_frame(48, 48, 24, -1, "R8 saturation");
        check("R8 count at 2047", pix_count, 2047);

        repeat (50) @(negedge clk);
        check("R10 no result left pending", q_c.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule